// File: doc/BRIEF.md
# Frame Pattern Bit Counter

This block counts clock edges through an 80-position serial frame. It advances only while a single serial level input shows the level that each position expects. The count climbs by one on every clock whose input level is correct. A clock with the wrong level sends it straight back to zero. A count that reaches 79 therefore means a complete frame with the expected marker pattern arrived without a break. On that cycle a one-clock frame-valid flag is raised, and the count then restarts for the next frame.

The expected pattern has four parts:
- Positions 0 to 11 expect high.
- Position 12 expects low.
- Positions 13 and 14 expect high.
- Positions 15 to 78 expect low.

A host samples the 7-bit count on a shared bus. The bus is driven only while the active-low output enable is asserted. Otherwise it is high-impedance.

Top module: `frame_pattern_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the count is 0 and the frame-valid flag is 0.
- R2: At counts 0 to 11, a clock edge with the serial input high raises the count by one.
- R3: At count 12, a clock edge with the serial input low moves the count to 13.
- R4: At counts 13 and 14, a clock edge with the serial input high raises the count by one.
- R5: At counts 15 to 78, a clock edge with the serial input low raises the count by one, so 64 low clocks take 15 to 79.
- R6: At any count from 0 to 78, a clock edge with the input at the opposite level to the one expected at that count returns the count to 0.
- R7: At count 79, the next clock edge returns the count to 0, whatever the input level.
- R8: The frame-valid output is 1 exactly on the cycles where the count is 79, and 0 on all other cycles.
- R9: With the enable input low, the count bus carries the count (binary, bit 0 = LSB). With the enable high, the bus is high-impedance and the count keeps advancing underneath.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, one edge per frame bit |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| bit_lvl_i | input | 1 | Serial level sampled on each clock edge |
| rd_en_n_i | input | 1 | Active-low bus enable |
| pos_bus_o | output | 7 | Count, or high-impedance when disabled |
| frame_ok_o | output | 1 | High while the count is 79 |

## Verification
Suppose the internal count holds a wrong value. Its effects appear at the ports either at once or within one clock:
- With the bus enabled, the wrong value is visible on the bus immediately.
- At the next edge the count steps or clears by the wrong rule.

A wrong expected level at any position shows as a clear where a step was due, or the reverse. The bench therefore breaks the pattern at every one of positions 0 to 78 and compares the count after each edge. A stuck or misplaced frame-valid flag differs from the count decode on the same cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int CNT_W = 7;

    typedef logic [CNT_W-1:0] fpc_pos_t;

    typedef struct packed {
        fpc_pos_t pos;
        logic     ok;
    } fpc_state_t;

    localparam fpc_state_t FPC_IDLE = '{pos: '0, ok: 1'b0};
endpackage

// File: rtl/fpc_level_map.sv
module fpc_level_map
    import fpc_pkg::*;
#(
    parameter int LEAD_ONES = 12,
    parameter int GAP_ZEROS = 1,
    parameter int MARK_ONES = 2,
    parameter int FRAME_LEN = 80
) (
    input  fpc_pos_t pos_i,
    output logic     want_hi_o,
    output logic     in_frame_o
);
    localparam int GAP_END  = LEAD_ONES + GAP_ZEROS;
    localparam int MARK_END = GAP_END + MARK_ONES;
    localparam int LAST     = FRAME_LEN - 1;

    localparam fpc_pos_t LEAD_P = fpc_pos_t'(LEAD_ONES);
    localparam fpc_pos_t GAP_P  = fpc_pos_t'(GAP_END);
    localparam fpc_pos_t MARK_P = fpc_pos_t'(MARK_END);
    localparam fpc_pos_t LAST_P = fpc_pos_t'(LAST);

    always_comb begin
        in_frame_o = (pos_i < LAST_P);
        if (pos_i < LEAD_P) begin
            want_hi_o = 1'b1;
        end else if (pos_i < GAP_P) begin
            want_hi_o = 1'b0;
        end else if (pos_i < MARK_P) begin
            want_hi_o = 1'b1;
        end else begin
            want_hi_o = 1'b0;
        end
    end
endmodule

// File: rtl/fpc_bus_drv.sv
module fpc_bus_drv #(
    parameter int W = 7
) (
    input  logic         en_n_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] bus_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign bus_o[b] = en_n_i ? 1'bz : val_i[b];
    end
endmodule

// File: rtl/frame_pattern_counter.sv
module frame_pattern_counter
    import fpc_pkg::*;
#(
    parameter int LEAD_ONES = 12,
    parameter int GAP_ZEROS = 1,
    parameter int MARK_ONES = 2,
    parameter int FRAME_LEN = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_lvl_i,
    input  logic             rd_en_n_i,
    output logic [CNT_W-1:0] pos_bus_o,
    output logic             frame_ok_o
);
    localparam fpc_pos_t LAST_P = fpc_pos_t'(FRAME_LEN - 1);

    fpc_state_t st_d, st_q;
    logic       want_hi;
    logic       in_frame;

    fpc_level_map #(
        .LEAD_ONES (LEAD_ONES),
        .GAP_ZEROS (GAP_ZEROS),
        .MARK_ONES (MARK_ONES),
        .FRAME_LEN (FRAME_LEN)
    ) u_map (
        .pos_i      (st_q.pos),
        .want_hi_o  (want_hi),
        .in_frame_o (in_frame)
    );

    always_comb begin
        st_d = st_q;
        if (in_frame && (bit_lvl_i == want_hi)) begin
            st_d.pos = st_q.pos + fpc_pos_t'(1);
        end else begin
            st_d.pos = '0;
        end
        st_d.ok = (st_d.pos == LAST_P);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FPC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    fpc_bus_drv #(.W(CNT_W)) u_drv (
        .en_n_i (rd_en_n_i),
        .val_i  (st_q.pos),
        .bus_o  (pos_bus_o)
    );

    assign frame_ok_o = st_q.ok;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
    import fpc_pkg::*;
#(
    parameter int LEAD_ONES = 12,
    parameter int GAP_ZEROS = 1,
    parameter int MARK_ONES = 2,
    parameter int FRAME_LEN = 80
) (
    input logic     clk,
    input logic     rst_n,
    input logic     lvl,
    input logic     en_n,
    input fpc_pos_t pos,
    input logic     ok,
    input fpc_pos_t bus
);
    localparam fpc_pos_t LEAD_P = fpc_pos_t'(LEAD_ONES);
    localparam fpc_pos_t TAIL_P = fpc_pos_t'(LEAD_ONES + GAP_ZEROS + MARK_ONES);
    localparam fpc_pos_t LAST_P = fpc_pos_t'(FRAME_LEN - 1);

    AST_LEAD_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pos < LEAD_P && !lvl) |=> pos == '0); // R2
    AST_GAP_LOW_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == LEAD_P && !lvl) |=> pos == LEAD_P + fpc_pos_t'(1)); // R3
    AST_TAIL_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= TAIL_P && pos < LAST_P && lvl) |=> pos == '0); // R5
    AST_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pos < LAST_P) |=> (pos == '0 || pos == $past(pos) + fpc_pos_t'(1))); // R6
    AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == LAST_P) |=> pos == '0); // R7
    AST_OK_ONLY_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> pos == LAST_P); // R8
    AST_LAST_SETS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == LAST_P) |-> ok); // R8
    AST_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |-> bus == pos); // R9
endmodule

bind frame_pattern_counter fpc_checker #(
    .LEAD_ONES (LEAD_ONES),
    .GAP_ZEROS (GAP_ZEROS),
    .MARK_ONES (MARK_ONES),
    .FRAME_LEN (FRAME_LEN)
) u_fpc_checker (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (bit_lvl_i),
    .en_n (rd_en_n_i),
    .pos  (st_q.pos),
    .ok   (st_q.ok),
    .bus  (pos_bus_o)
);

// File: tb/frame_pattern_counter_bench.sv
`timescale 1ns/1ps
module frame_pattern_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvl = 1'b0;
    logic       en_n = 1'b0;
    wire  [6:0] bus;
    logic       ok;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    frame_pattern_counter u_frame_pattern_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_lvl_i  (lvl),
        .rd_en_n_i  (en_n),
        .pos_bus_o  (bus),
        .frame_ok_o (ok)
    );

    function automatic bit want(input int p);
        return (p < 12) || (p == 13) || (p == 14);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic step(input bit l);
        string tag;
        @(negedge clk);
        lvl = l;
        if (model == 79)         tag = "R7";
        else if (l != want(model)) tag = "R6";
        else if (model < 12)     tag = "R2";
        else if (model == 12)    tag = "R3";
        else if (model < 15)     tag = "R4";
        else                     tag = "R5";
        if (model == 79)           model = 0;
        else if (l == want(model)) model = model + 1;
        else                       model = 0;
        @(posedge clk);
        #5;
        check(tag, int'(bus), model);
        check("R8", int'(ok), (model == 79) ? 1 : 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #35;
        check("R1", int'(bus), 0);
        check("R1", int'(ok), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check("R1", int'(bus), 0);

        // Two back-to-back full frames, final clock high then low (R7).
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 79; p++) step(want(p));
            step(f == 0);
        end
        step(1'b0);

        // Break the pattern at every position (R6).
        for (int p = 0; p < 79; p++) begin
            for (int k = 0; k < p; k++) step(want(k));
            step(!want(p));
        end

        // Idle input patterns from zero.
        for (int k = 0; k < 6; k++) step(1'b0);
        for (int k = 0; k < 10; k++) step(k[0]);

        // Bus release while the count keeps advancing (R9).
        step(1'b0);
        for (int k = 0; k < 5; k++) step(1'b1);
        @(negedge clk);
        en_n = 1'b1;
        #1;
        checks++;
        if (!(bus === 7'bzzzzzzz || bus === 7'd0)) begin
            errors++;
            $display("FAIL R9 actual=%0d expected=z", bus);
        end
        lvl = 1'b1;
        @(posedge clk);
        model = model + 1;
        #5;
        checks++;
        if (!(bus === 7'bzzzzzzz || bus === 7'd0)) begin
            errors++;
            $display("FAIL R9 actual=%0d expected=z", bus);
        end
        @(negedge clk);
        en_n = 1'b0;
        #1;
        check("R9", int'(bus), model);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule